// File: doc/BRIEF.md
# Triggered ADC Burst Sequencer

This block is the master side of the serial link to a 12-bit successive-approximation converter whose channel commands take effect through a two-frame pipeline. Each rising edge on the trigger input starts one burst. The block picks the next entry of a programmed channel list and sends the channel command in the first frame of the burst. It then runs one frame per frame period until it has read N valid conversions. After the burst it falls back to the armed state. The next trigger moves on to the next list entry, and the list wraps around after its last slot.

The converter returns each word two frames after the frame whose chip-select falling edge took the analog sample. The sequencer therefore runs N+2 frames per burst and throws away the first two returned words. It pulses a timestamp strobe on the chip-select falling edge of each of the first N frames, because those edges are the sampling instants. Each kept word is presented as a sample with its 12-bit result, the channel field it came back with, and a flag on the first sample of the burst.

Two error conditions are recorded. A returned channel field that differs from the commanded channel sets a sticky error. A trigger that arrives while a burst is still running is dropped, and a saturating counter records it.

Top module: `adc_trig_sequencer`

## Requirements
- R1: While reset is held, and at the first cycle after it, `adc_cs_n` is 1, `adc_sclk` is 0, `adc_sdi` is 0, `smp_valid` is 0, `err_chan` is 0 and `ovr_count` is 0.
- R2: Each frame has exactly 16 SCLK rising edges inside one chip-select-low window. SCLK is low whenever chip select is high. Each SCLK level lasts CLK_DIV clock cycles, so the first rising edge comes CLK_DIV cycles after chip select falls.
- R3: The first frame of a burst carries, MSB first, the command {4'b0001, 1'b1, channel[3:0], 1'b1, 1'b0, 1'b0, 4'b0000}. Every other frame carries all zeros.
- R4: SDI changes only when SCLK goes low or when chip select falls, and it holds steady while SCLK is high. SDO is captured on SCLK rising edges.
- R5: A burst has exactly N+2 frames, where N is `cfg_samples` and 0 counts as 1. Chip-select falling edges are spaced by max(`cfg_frame_period`, 32*CLK_DIV+CS_HIGH_MIN) clock cycles.
- R6: The first two words returned in a burst are dropped. Each later word gives one `smp_valid` pulse with bits 11:0 on `smp_data` and bits 15:12 on `smp_chan`. `smp_first` is set only on the first sample of the burst.
- R7: `ts_strobe` is high in exactly the cycle in which chip select falls for each of the first N frames of a burst, and never in the last two frames.
- R8: Burst number b after reset uses list slot b mod NUM_SLOTS. Slot i is `cfg_chan_list[4*i+3:4*i]`.
- R9: A kept word whose channel field differs from the commanded channel sets `err_chan`, and `err_chan` stays set until reset.
- R10: A trigger edge during a burst has no effect on the frames, and it adds one to `ovr_count`, which holds at 2^OVR_W-1.
- R11: Only a rising edge of `trig` starts a burst. A trigger held high across the end of a burst starts no second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Burst trigger, rising-edge sensitive, synchronous to clk |
| cfg_samples | input | CNT_W | Valid samples per burst (0 treated as 1) |
| cfg_frame_period | input | PER_W | Frame spacing in clock cycles |
| cfg_chan_list | input | 4*NUM_SLOTS | Channel numbers, slot i in bits 4i+3:4i |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idle low |
| adc_sdi | output | 1 | Command data to the converter |
| adc_sdo | input | 1 | Conversion data from the converter |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_data | output | 12 | Conversion result |
| smp_chan | output | 4 | Channel field returned with the result |
| smp_first | output | 1 | First sample of the burst |
| ts_strobe | output | 1 | Sampling-instant strobe |
| err_chan | output | 1 | Sticky channel mismatch |
| ovr_count | output | OVR_W | Saturating count of ignored triggers |

## Verification
The bench drives a behavioural converter that tags every sampling frame with a distinct value. Matching each sample against the value of the frame two chip-select edges earlier therefore separates a correct pipeline offset from one that is off by one frame in either direction. Bursts are run with several sample counts (including zero) and frame periods above and below the minimum, and the sequence runs through every list slot and wraps around. This separates slot indexing, burst length and period clamping errors. Further runs cover bursts hit by repeated triggers, a trigger held high through the end of a burst, and a converter that returns a corrupted channel field. These tell the overrun, edge-only and sticky-error rules apart from plain burst behaviour.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int WORD_W = 16;
  localparam int CH_W   = 4;
  localparam int DATA_W = 12;

  localparam logic [3:0] MODE_MANUAL = 4'b0001;

  typedef enum logic [0:0] {
    SEQ_ARMED = 1'b0,
    SEQ_BURST = 1'b1
  } seq_state_t;

  // Manual-mode channel command: mode, program, channel, double range,
  // no power-down, no GPIO update, four zero bits.
  function automatic logic [WORD_W-1:0] chan_cmd(input logic [CH_W-1:0] ch);
    return {MODE_MANUAL, 1'b1, ch, 1'b1, 1'b0, 1'b0, 4'b0000};
  endfunction

endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
  import adc_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdi,
  input  logic              sdo
);

  localparam int HC_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int EDGES = 2 * WORD_W;
  localparam int EC_W  = $clog2(EDGES);

  logic              active;
  logic [HC_W-1:0]   hcnt;
  logic [EC_W-1:0]   ecnt;
  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      hcnt    <= '0;
      ecnt    <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
      done    <= 1'b0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      sdi     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          cs_n   <= 1'b0;
          sclk   <= 1'b0;
          sdi    <= tx_word[WORD_W-1];
          tx_sh  <= {tx_word[WORD_W-2:0], 1'b0};
          hcnt   <= '0;
          ecnt   <= '0;
        end
      end else if (hcnt == HC_W'(HALF_DIV - 1)) begin
        hcnt <= '0;
        ecnt <= ecnt + EC_W'(1);
        if (!ecnt[0]) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[WORD_W-2:0], sdo};
        end else begin
          sclk <= 1'b0;
          if (ecnt == EC_W'(EDGES - 1)) begin
            active  <= 1'b0;
            cs_n    <= 1'b1;
            done    <= 1'b1;
            rx_word <= rx_sh;
            sdi     <= 1'b0;
          end else begin
            sdi   <= tx_sh[WORD_W-1];
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
          end
        end
      end else begin
        hcnt <= hcnt + HC_W'(1);
      end
    end
  end

endmodule

// File: rtl/adc_burst_ctrl.sv
module adc_burst_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CLK_DIV     = 2,
  parameter int CS_HIGH_MIN = 8,
  parameter int NUM_SLOTS   = 4,
  parameter int CNT_W       = 10,
  parameter int PER_W       = 16,
  parameter int OVR_W       = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      trig,
  input  logic [CNT_W-1:0]          cfg_samples,
  input  logic [PER_W-1:0]          cfg_frame_period,
  input  logic [CH_W*NUM_SLOTS-1:0] cfg_chan_list,
  input  logic                      eng_done,
  output logic                      eng_start,
  output logic [WORD_W-1:0]         eng_tx,
  output logic                      ts_strobe,
  output logic                      keep_word,
  output logic                      first_word,
  output logic [CH_W-1:0]           burst_chan,
  output logic [OVR_W-1:0]          ovr_count
);

  localparam int FRAME_CLKS = 2 * WORD_W * CLK_DIV;
  localparam int MIN_PERIOD = FRAME_CLKS + CS_HIGH_MIN;
  localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [PER_W-1:0] MIN_P   = PER_W'(MIN_PERIOD);
  localparam logic [OVR_W-1:0] OVR_MAX = {OVR_W{1'b1}};

  if (CLK_DIV < 1) begin : g_bad_div
    $error("CLK_DIV must be at least 1");
  end
  if (CS_HIGH_MIN < 1) begin : g_bad_gap
    $error("CS_HIGH_MIN must be at least 1");
  end
  if (MIN_PERIOD >= (2 ** PER_W)) begin : g_bad_per
    $error("minimum frame period does not fit in PER_W bits");
  end

  logic [CH_W-1:0] slot_ch [NUM_SLOTS];
  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
    assign slot_ch[gi] = cfg_chan_list[gi*CH_W +: CH_W];
  end

  seq_state_t      state;
  logic            trig_q;
  logic [PER_W-1:0] tmr;
  logic [PER_W-1:0] per_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W:0]  issued;
  logic [CNT_W:0]  rxcnt;
  logic [SLOT_W-1:0] slot;

  logic            trig_rise;
  logic [PER_W-1:0] eff_per;
  logic [CNT_W-1:0] eff_n;
  logic [CNT_W:0]  total;
  logic            last_tick;

  assign trig_rise = trig & ~trig_q;
  assign eff_per   = (cfg_frame_period < MIN_P) ? MIN_P : cfg_frame_period;
  assign eff_n     = (cfg_samples == '0) ? CNT_W'(1) : cfg_samples;
  assign total     = {1'b0, n_q} + (CNT_W+1)'(2);
  assign last_tick = (tmr == per_q - PER_W'(1));

  assign eng_start  = (state == SEQ_BURST) && (tmr == '0) && (issued != total);
  assign eng_tx     = (issued == '0) ? chan_cmd(burst_chan) : '0;
  assign keep_word  = eng_done && (rxcnt >= (CNT_W+1)'(2));
  assign first_word = (rxcnt == (CNT_W+1)'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_ARMED;
      trig_q     <= 1'b0;
      tmr        <= '0;
      per_q      <= MIN_P;
      n_q        <= CNT_W'(1);
      issued     <= '0;
      rxcnt      <= '0;
      slot       <= '0;
      burst_chan <= '0;
      ovr_count  <= '0;
      ts_strobe  <= 1'b0;
    end else begin
      trig_q    <= trig;
      ts_strobe <= eng_start && (issued < {1'b0, n_q});
      if (state == SEQ_ARMED) begin
        if (trig_rise) begin
          state      <= SEQ_BURST;
          burst_chan <= slot_ch[slot];
          n_q        <= eff_n;
          per_q      <= eff_per;
          tmr        <= '0;
          issued     <= '0;
          rxcnt      <= '0;
        end
      end else begin
        if (trig_rise && (ovr_count != OVR_MAX)) begin
          ovr_count <= ovr_count + OVR_W'(1);
        end
        tmr <= last_tick ? '0 : tmr + PER_W'(1);
        if (eng_start) begin
          issued <= issued + (CNT_W+1)'(1);
        end
        if (eng_done) begin
          rxcnt <= rxcnt + (CNT_W+1)'(1);
        end
        if ((issued == total) && last_tick) begin
          state <= SEQ_ARMED;
          slot  <= (slot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot + SLOT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/adc_sample_out.sv
module adc_sample_out
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              keep_word,
  input  logic              first_word,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [CH_W-1:0]   exp_chan,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic [CH_W-1:0]   smp_chan,
  output logic              smp_first,
  output logic              err_chan
);

  logic [CH_W-1:0] ret_chan;
  assign ret_chan = rx_word[WORD_W-1 -: CH_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_chan  <= '0;
      smp_first <= 1'b0;
      err_chan  <= 1'b0;
    end else begin
      smp_valid <= keep_word;
      smp_first <= keep_word && first_word;
      if (keep_word) begin
        smp_data <= rx_word[DATA_W-1:0];
        smp_chan <= ret_chan;
        if (ret_chan != exp_chan) begin
          err_chan <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adc_trig_sequencer.sv
module adc_trig_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CLK_DIV     = 2,
  parameter int CS_HIGH_MIN = 8,
  parameter int NUM_SLOTS   = 4,
  parameter int CNT_W       = 10,
  parameter int PER_W       = 16,
  parameter int OVR_W       = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      trig,
  input  logic [CNT_W-1:0]          cfg_samples,
  input  logic [PER_W-1:0]          cfg_frame_period,
  input  logic [CH_W*NUM_SLOTS-1:0] cfg_chan_list,
  output logic                      adc_cs_n,
  output logic                      adc_sclk,
  output logic                      adc_sdi,
  input  logic                      adc_sdo,
  output logic                      smp_valid,
  output logic [DATA_W-1:0]         smp_data,
  output logic [CH_W-1:0]           smp_chan,
  output logic                      smp_first,
  output logic                      ts_strobe,
  output logic                      err_chan,
  output logic [OVR_W-1:0]          ovr_count
);

  logic              eng_start;
  logic              eng_done;
  logic [WORD_W-1:0] eng_tx;
  logic [WORD_W-1:0] eng_rx;
  logic              keep_word;
  logic              first_word;
  logic [CH_W-1:0]   burst_chan;

  adc_burst_ctrl #(
    .CLK_DIV     (CLK_DIV),
    .CS_HIGH_MIN (CS_HIGH_MIN),
    .NUM_SLOTS   (NUM_SLOTS),
    .CNT_W       (CNT_W),
    .PER_W       (PER_W),
    .OVR_W       (OVR_W)
  ) u_ctrl (
    .clk              (clk),
    .rst              (rst),
    .trig             (trig),
    .cfg_samples      (cfg_samples),
    .cfg_frame_period (cfg_frame_period),
    .cfg_chan_list    (cfg_chan_list),
    .eng_done         (eng_done),
    .eng_start        (eng_start),
    .eng_tx           (eng_tx),
    .ts_strobe        (ts_strobe),
    .keep_word        (keep_word),
    .first_word       (first_word),
    .burst_chan       (burst_chan),
    .ovr_count        (ovr_count)
  );

  adc_spi_frame #(
    .HALF_DIV (CLK_DIV)
  ) u_spi (
    .clk     (clk),
    .rst     (rst),
    .start   (eng_start),
    .tx_word (eng_tx),
    .done    (eng_done),
    .rx_word (eng_rx),
    .cs_n    (adc_cs_n),
    .sclk    (adc_sclk),
    .sdi     (adc_sdi),
    .sdo     (adc_sdo)
  );

  adc_sample_out u_out (
    .clk        (clk),
    .rst        (rst),
    .keep_word  (keep_word),
    .first_word (first_word),
    .rx_word    (eng_rx),
    .exp_chan   (burst_chan),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .smp_chan   (smp_chan),
    .smp_first  (smp_first),
    .err_chan   (err_chan)
  );

endmodule

// File: rtl/adc_trig_sequencer_chk.sv
module adc_trig_sequencer_chk #(
  parameter int OVR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             adc_cs_n,
  input logic             adc_sclk,
  input logic             adc_sdi,
  input logic             smp_valid,
  input logic             smp_first,
  input logic             ts_strobe,
  input logic             err_chan,
  input logic [OVR_W-1:0] ovr_count
);

  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> !adc_sclk);

  // R4
  sdi_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    adc_sclk |-> $stable(adc_sdi));

  // R7
  ts_at_cs_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ts_strobe |-> $fell(adc_cs_n));

  // R6
  first_is_valid_chk: assert property (@(posedge clk) disable iff (rst)
    smp_first |-> smp_valid);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(err_chan) |-> err_chan);

  // R10
  ovr_no_decrease_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_count >= $past(ovr_count));

endmodule

bind adc_trig_sequencer adc_trig_sequencer_chk #(.OVR_W(OVR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .adc_cs_n  (adc_cs_n),
  .adc_sclk  (adc_sclk),
  .adc_sdi   (adc_sdi),
  .smp_valid (smp_valid),
  .smp_first (smp_first),
  .ts_strobe (ts_strobe),
  .err_chan  (err_chan),
  .ovr_count (ovr_count)
);

// File: tb/adc_trig_sequencer_tb.sv
`timescale 1ns/1ps
module adc_trig_sequencer_tb;

  localparam int CLK_DIV     = 2;
  localparam int CS_HIGH_MIN = 4;
  localparam int NUM_SLOTS   = 4;
  localparam int CNT_W       = 8;
  localparam int PER_W       = 12;
  localparam int OVR_W       = 4;
  localparam int MIN_PER     = 32 * CLK_DIV + CS_HIGH_MIN;
  localparam int LOG_N       = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic [CNT_W-1:0] cfg_samples = '0;
  logic [PER_W-1:0] cfg_frame_period = '0;
  logic [4*NUM_SLOTS-1:0] cfg_chan_list = {4'd15, 4'd0, 4'd9, 4'd3};
  logic adc_cs_n, adc_sclk, adc_sdi, adc_sdo;
  logic smp_valid, smp_first, ts_strobe, err_chan;
  logic [11:0] smp_data;
  logic [3:0]  smp_chan;
  logic [OVR_W-1:0] ovr_count;

  always #5 clk = ~clk;

  adc_trig_sequencer #(
    .CLK_DIV(CLK_DIV), .CS_HIGH_MIN(CS_HIGH_MIN), .NUM_SLOTS(NUM_SLOTS),
    .CNT_W(CNT_W), .PER_W(PER_W), .OVR_W(OVR_W)
  ) u_dut (
    .clk(clk), .rst(rst), .trig(trig), .cfg_samples(cfg_samples),
    .cfg_frame_period(cfg_frame_period), .cfg_chan_list(cfg_chan_list),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan),
    .smp_first(smp_first), .ts_strobe(ts_strobe), .err_chan(err_chan),
    .ovr_count(ovr_count)
  );

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  function automatic int fval(input int m);
    return (m * 37 + 5) & 12'hFFF;
  endfunction

  int         mdl_cnt = 0;
  logic [3:0] sel = 4'd0, q0 = 4'd0, q1 = 4'd0;
  logic [15:0] in_sh = 16'd0, out_sh = 16'd0;
  bit         fault = 0;

  assign adc_sdo = out_sh[15];

  always @(negedge adc_cs_n) begin
    out_sh = {q1 ^ {3'b000, fault}, 12'(fval(mdl_cnt - 2))};
    mdl_cnt++;
  end
  always @(negedge adc_sclk) if (!adc_cs_n) out_sh = {out_sh[14:0], 1'b0};
  always @(posedge adc_sclk) in_sh = {in_sh[14:0], adc_sdi};
  always @(posedge adc_cs_n) begin
    if (in_sh[15:12] == 4'b0001 && in_sh[11]) sel = in_sh[10:7];
    q1 = q0;
    q0 = sel;
    in_sh = 16'd0;
  end

  // ---------------- monitor ----------------
  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_fr = 0, n_ts = 0, n_smp = 0, sdi_bad = 0, bitcnt = 0;
  int fall_cyc [LOG_N];
  int fr_m     [LOG_N];
  int rise_off [LOG_N];
  int nbits    [LOG_N];
  int sdi_w    [LOG_N];
  int ts_cyc   [LOG_N];
  int s_data   [LOG_N];
  int s_chan   [LOG_N];
  int s_first  [LOG_N];
  logic [15:0] cur_w = 16'd0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_sdi = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !adc_cs_n && n_fr < LOG_N) begin
        fall_cyc[n_fr] = cyc;
        fr_m[n_fr] = mdl_cnt - 1;
        rise_off[n_fr] = -1;
        bitcnt = 0;
      end
      if (!prev_sclk && adc_sclk && !adc_cs_n && n_fr < LOG_N) begin
        if (bitcnt == 0) rise_off[n_fr] = cyc - fall_cyc[n_fr];
        cur_w = {cur_w[14:0], adc_sdi};
        bitcnt++;
      end
      if (!prev_cs && adc_cs_n && n_fr < LOG_N) begin
        sdi_w[n_fr] = int'(cur_w);
        nbits[n_fr] = bitcnt;
        n_fr++;
      end
      if (adc_sclk && prev_sclk && adc_sdi != prev_sdi) sdi_bad++;
      if (ts_strobe && n_ts < LOG_N) begin
        ts_cyc[n_ts] = cyc;
        n_ts++;
      end
      if (smp_valid && n_smp < LOG_N) begin
        s_data[n_smp]  = int'(smp_data);
        s_chan[n_smp]  = int'(smp_chan);
        s_first[n_smp] = int'(smp_first);
        n_smp++;
      end
    end
    prev_cs = adc_cs_n;
    prev_sclk = adc_sclk;
    prev_sdi = adc_sdi;
  end

  // ---------------- helpers ----------------
  int slot_i = 0;

  function automatic int slot_chan(input int s);
    return int'(cfg_chan_list[4*s +: 4]);
  endfunction

  function automatic int cmd_of(input int ch);
    return int'({4'b0001, 1'b1, 4'(ch), 1'b1, 1'b0, 1'b0, 4'b0000});
  endfunction

  task automatic clear_logs();
    n_fr = 0; n_ts = 0; n_smp = 0; sdi_bad = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic wait_done(input int nexp, input int eff);
    while (n_fr < nexp) @(posedge clk);
    repeat (eff + 10) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_burst(input int ch, input int n, input int eff, input bit flt);
    int nexp = n + 2;
    int lim;
    chk(n_fr == nexp, "R5 frames per burst", n_fr, nexp);
    lim = (n_fr < nexp) ? n_fr : nexp;
    for (int i = 0; i < lim; i++) begin
      chk(nbits[i] == 16, "R2 SCLK rises per frame", nbits[i], 16);
      chk(rise_off[i] == CLK_DIV, "R2 first SCLK rise offset", rise_off[i], CLK_DIV);
      if (i == 0) chk(sdi_w[0] == cmd_of(ch), "R3 R8 command word", sdi_w[0], cmd_of(ch));
      else        chk(sdi_w[i] == 0, "R3 zero word", sdi_w[i], 0);
      if (i > 0) chk(fall_cyc[i] - fall_cyc[i-1] == eff, "R5 frame spacing",
                     fall_cyc[i] - fall_cyc[i-1], eff);
    end
    chk(sdi_bad == 0, "R4 SDI stable while SCLK high", sdi_bad, 0);
    chk(n_smp == n, "R6 sample count", n_smp, n);
    for (int k = 0; k < n && k < n_smp && k < lim; k++) begin
      chk(s_data[k] == fval(fr_m[k]), "R6 sample data", s_data[k], fval(fr_m[k]));
      chk(s_chan[k] == (flt ? (ch ^ 1) : ch), "R8 sample channel", s_chan[k], flt ? (ch ^ 1) : ch);
      chk(s_first[k] == (k == 0), "R6 first flag", s_first[k], k == 0);
    end
    chk(n_ts == n, "R7 strobe count", n_ts, n);
    for (int k = 0; k < n && k < n_ts && k < lim; k++)
      chk(ts_cyc[k] == fall_cyc[k], "R7 strobe on sampling CS fall", ts_cyc[k], fall_cyc[k]);
  endtask

  task automatic run_burst(input int n_cfg, input int per, input bit flt);
    int n   = (n_cfg == 0) ? 1 : n_cfg;
    int eff = (per < MIN_PER) ? MIN_PER : per;
    int ch  = slot_chan(slot_i);
    cfg_samples = CNT_W'(n_cfg);
    cfg_frame_period = PER_W'(per);
    fault = flt;
    clear_logs();
    pulse_trig();
    wait_done(n + 2, eff);
    check_burst(ch, n, eff, flt);
    fault = 0;
    slot_i = (slot_i + 1) % NUM_SLOTS;
  endtask

  // ---------------- scenarios ----------------
  task automatic test_reset();
    @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 cs_n idle", adc_cs_n, 1);
    chk(adc_sclk == 1'b0, "R1 sclk idle", adc_sclk, 0);
    chk(adc_sdi == 1'b0, "R1 sdi idle", adc_sdi, 0);
    chk(smp_valid == 1'b0, "R1 no sample", smp_valid, 0);
    chk(err_chan == 1'b0, "R1 error clear", err_chan, 0);
    chk(ovr_count == '0, "R1 overrun clear", int'(ovr_count), 0);
  endtask

  task automatic test_basic();
    run_burst(3, 100, 0);          // slot 0
    run_burst(0, 50, 0);           // slot 1, N=0 -> 1, period clamped
  endtask

  task automatic test_slot_wrap();
    run_burst(2, 80, 0);           // slot 2
    run_burst(2, 80, 0);           // slot 3
    run_burst(2, 80, 0);           // slot 0 again (R8 wrap)
  endtask

  task automatic test_overrun();
    int ch = slot_chan(slot_i);
    cfg_samples = CNT_W'(8);
    cfg_frame_period = PER_W'(100);
    clear_logs();
    pulse_trig();
    while (n_fr < 1) @(posedge clk);
    repeat (3) pulse_trig();
    @(negedge clk);
    chk(int'(ovr_count) == 3, "R10 overrun count", int'(ovr_count), 3);
    repeat (20) pulse_trig();
    @(negedge clk);
    chk(int'(ovr_count) == 15, "R10 overrun saturates", int'(ovr_count), 15);
    wait_done(10, 100);
    check_burst(ch, 8, 100, 0);
    slot_i = (slot_i + 1) % NUM_SLOTS;
  endtask

  task automatic test_level_trig();
    int ch = slot_chan(slot_i);
    int ovr0 = int'(ovr_count);
    cfg_samples = CNT_W'(2);
    cfg_frame_period = PER_W'(70);
    clear_logs();
    @(negedge clk) trig = 1'b1;
    wait_done(4, 70);
    repeat (200) @(posedge clk);
    @(negedge clk) trig = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check_burst(ch, 2, 70, 0);
    chk(int'(ovr_count) == ovr0, "R11 held trigger adds no overrun", int'(ovr_count), ovr0);
    slot_i = (slot_i + 1) % NUM_SLOTS;
  endtask

  task automatic test_mismatch();
    chk(err_chan == 1'b0, "R9 no error on matching channels", err_chan, 0);
    run_burst(2, 80, 1);
    chk(err_chan == 1'b1, "R9 error on wrong channel field", err_chan, 1);
    run_burst(2, 80, 0);
    chk(err_chan == 1'b1, "R9 error stays set", err_chan, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    test_reset();
    @(negedge clk) rst = 1'b0;
    test_reset();
    test_basic();
    test_slot_wrap();
    test_overrun();
    test_level_trig();
    test_mismatch();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    misses++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_run();
  end

endmodule